// File: doc/BRIEF.md
# Step-Addressed Byte Memory

This block is a small byte-wide memory with no address pins. An internal pointer selects the location. The pointer moves one place for each rising edge seen on a step input. A direction input chooses whether each step counts up or down, and a clear input sends the pointer back to location 0. Because the pointer only moves one place per step, the number of steps needed to reach a location equals its distance from the current pointer.

While the write input is high, the byte on the data input is stored at the pointer and the data output is forced to zero. The memory therefore either reads or writes in a given cycle, never both. When write is low, the data output shows the byte at the current pointer with no added register delay. The current pointer is also brought out, so the user can always see which location is selected.

Top module: `byte_step_mem`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `ptr` is 0.
- R2: With `dir` = 0 (up), a 0-to-1 change of `step` between two clock edges makes `ptr` one higher at the clock edge where `step` is first sampled high.
- R3: Holding `step` high for several cycles moves `ptr` only once. A new move needs `step` to go low and then high again.
- R4: With `dir` = 1 (down), each rising edge of `step` makes `ptr` one lower.
- R5: The pointer wraps modulo the depth in both directions: up from 255 gives 0, and down from 0 gives 255.
- R6: When `ptr_clr` is high at a clock edge, `ptr` becomes 0 at that edge, even if a step rising edge arrives in the same cycle.
- R7: When `wr` is high at a clock edge, the byte on `din` is stored at the location `ptr` held before that edge. That byte is read back later whenever `ptr` returns to that location and `wr` is low.
- R8: While `wr` is high, `dout` is 0.
- R9: A step rising edge that arrives in a cycle where `wr` is high is ignored: `ptr` keeps its value.
- R10: While `wr` is low, `dout` shows the byte at the current `ptr` in the same cycle that `ptr` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer and the step detector |
| din | input | 8 | Byte to store |
| wr | input | 1 | Write strobe; while it is high, `dout` is forced to zero |
| step | input | 1 | Step input; each rising edge moves the pointer once |
| dir | input | 1 | Step direction: 0 counts up, 1 counts down |
| ptr_clr | input | 1 | Synchronous clear of the pointer to 0; wins over a step |
| dout | output | 8 | Byte at the pointer, or 0 while writing |
| ptr | output | 8 | Current pointer value |

## Verification
A wrong pointer value appears on `ptr` at the first clock edge after the faulty step, clear or write. A missed or doubled step, or a step accepted during a write, shows up there at once. A fault in the storage path only appears when the pointer comes back to the damaged location. For that reason the tests write a pattern, walk away from it (including across the wrap point), return with a clear and then step pulses, and compare `dout` in the same cycle the pointer lands on each location.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } step_dir_e;
endpackage

// File: rtl/bsm_step_detect.sv
module bsm_step_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic step_in,
   output logic step_rise
);
   logic step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= step_in;
   end

   assign step_rise = step_in & ~step_q;
endmodule

// File: rtl/bsm_pointer.sv
module bsm_pointer
   import bsm_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_rise,
   input  step_dir_e        dir,
   input  logic             clr,
   input  logic             wr,
   output logic [PTR_W-1:0] ptr
);
   generate
      if (PTR_W < 1) begin : g_bad_width
         $error("bsm_pointer: PTR_W must be at least 1");
      end
   endgenerate

   logic             move;
   logic [PTR_W-1:0] ptr_nx;

   assign move = step_rise & ~wr;

   always_comb begin
      ptr_nx = ptr;
      if (clr)                  ptr_nx = '0;
      else if (move) begin
         if (dir == DIR_UP)     ptr_nx = ptr + 1'b1;
         else                   ptr_nx = ptr - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_nx;
   end

   // R6
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0));

   // R9
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> $stable(ptr));

   // R3
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step_rise) |=> $stable(ptr));

   // R2
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_rise && !wr && !clr && dir == DIR_UP)
         |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

   // R4
   dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_rise && !wr && !clr && dir == DIR_DN)
         |=> (ptr == PTR_W'($past(ptr) - 1'b1)));
endmodule

// File: rtl/bsm_store.sv
module bsm_store #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << PTR_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("bsm_store: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/byte_step_mem.sv
module byte_step_mem
   import bsm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              wr,
   input  logic              step,
   input  logic              dir,
   input  logic              ptr_clr,
   output logic [DATA_W-1:0] dout,
   output logic [PTR_W-1:0]  ptr
);
   generate
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("byte_step_mem: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic              step_rise;
   logic [DATA_W-1:0] rd_word;

   bsm_step_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_in   (step),
      .step_rise (step_rise)
   );

   bsm_pointer #(.PTR_W(PTR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_rise (step_rise),
      .dir       (step_dir_e'(dir)),
      .clr       (ptr_clr),
      .wr        (wr),
      .ptr       (ptr)
   );

   bsm_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
      .clk   (clk),
      .we    (wr),
      .addr  (ptr),
      .wdata (din),
      .rdata (rd_word)
   );

   assign dout = wr ? '0 : rd_word;

   // R7
   wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr) && !wr && $stable(ptr)) |-> (dout == $past(din)));
endmodule

// File: tb/sim_byte_step_mem.sv
module sim_byte_step_mem;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] din = '0;
   logic       wr = 1'b0;
   logic       step = 1'b0;
   logic       dir = 1'b0;
   logic       ptr_clr = 1'b0;
   logic [7:0] dout;
   logic [7:0] ptr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   byte_step_mem u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .wr(wr), .step(step),
      .dir(dir), .ptr_clr(ptr_clr), .dout(dout), .ptr(ptr)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic pulse();
      step = 1'b1; cyc();
      step = 1'b0; cyc();
   endtask

   task automatic go_to(input int loc);
      ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0;
      dir = 1'b0;
      for (int i = 0; i < loc; i++) pulse();
   endtask

   task automatic put(input logic [7:0] b);
      wr = 1'b1; din = b; cyc();
      chk("R8", dout, 8'h00);
      wr = 1'b0; din = 8'h00;
   endtask

   task automatic t_reset();
      chk("R1", ptr, 8'd0);
   endtask

   task automatic t_up();
      dir = 1'b0;
      for (int i = 0; i < 3; i++) pulse();
      chk("R2", ptr, 8'd3);
   endtask

   task automatic t_hold();
      step = 1'b1;
      for (int i = 0; i < 4; i++) cyc();
      chk("R3", ptr, 8'd4);
      step = 1'b0; cyc();
      chk("R3", ptr, 8'd4);
   endtask

   task automatic t_down();
      dir = 1'b1;
      pulse(); pulse();
      chk("R4", ptr, 8'd2);
      dir = 1'b0;
   endtask

   task automatic t_wrap();
      go_to(0);
      dir = 1'b1; pulse();
      chk("R5", ptr, 8'd255);
      dir = 1'b0; pulse();
      chk("R5", ptr, 8'd0);
   endtask

   task automatic t_clr();
      go_to(5);
      chk("R6", ptr, 8'd5);
      step = 1'b1; ptr_clr = 1'b1; cyc();
      chk("R6", ptr, 8'd0);
      step = 1'b0; ptr_clr = 1'b0; cyc();
      chk("R6", ptr, 8'd0);
   endtask

   task automatic t_write_read();
      go_to(0);
      for (int i = 0; i < 6; i++) begin
         put(8'h3C ^ 8'(i * 37));
         pulse();
      end
      ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0;
      chk("R7", dout, 8'h3C);
      for (int i = 1; i < 6; i++) begin
         step = 1'b1; cyc();
         chk("R10", dout, 8'h3C ^ 8'(i * 37));
         step = 1'b0; cyc();
      end
      // location 255, reached by wrapping down, then read back
      ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0;
      dir = 1'b1; pulse(); dir = 1'b0;
      put(8'hE7);
      pulse();
      chk("R7", dout, 8'h3C);
      dir = 1'b1; pulse(); dir = 1'b0;
      chk("R7", dout, 8'hE7);
   endtask

   task automatic t_step_in_write();
      go_to(9);
      wr = 1'b1; din = 8'h5A; step = 1'b1; cyc();
      chk("R8", dout, 8'h00);
      chk("R9", ptr, 8'd9);
      wr = 1'b0; din = 8'h00; cyc();
      chk("R9", ptr, 8'd9);
      chk("R7", dout, 8'h5A);
      step = 1'b0; cyc();
      chk("R9", ptr, 8'd9);
   endtask

   initial begin
      cyc(); cyc();
      t_reset();
      rst_n = 1'b1; cyc();
      t_reset();
      t_up();
      t_hold();
      t_down();
      t_wrap();
      t_clr();
      t_write_read();
      t_step_in_write();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule